// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a countdown watchdog with a small register file on a synchronous register bus. Its interface has a word address, 16-bit write data, a write strobe, two byte enables and combinational read data. A prescaler divides the clock into ticks. While the timer is not halted, a counter decrements once per tick. Software keeps the system alive by writing the reload register, which copies the programmed timeout into the counter.

If the counter reaches zero and another tick arrives, the block expires. On a first expiry it sets a timeout status flag and reloads itself. If the system-management interrupt is enabled, the first expiry also pulses an interrupt request. If the timeout flag is still set at the next expiry, the block sets a second-timeout flag and a boot flag and pulses a system reset request. A no-reboot bit suppresses that reset request. A hardware lock input can force the no-reboot bit to stay set.

The second-timeout and boot flags are cleared only by the power-on reset. They survive the ordinary reset that the reset request causes, so software can find out after restart why the system reset.

Register map, by word address:
- 0: reload. A write triggers a reload; a read returns the current count.
- 1: timeout value.
- 2: control. Bit 0 is no-reboot, bit 1 is interrupt enable, bit 3 is halt and bit 9 is a spare read/write bit.
- 3: status 1. Bit 3 is the timeout flag.
- 4: status 2. Bit 1 is the second-timeout flag and bit 2 is the boot flag.

Unused addresses read as zero.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the outputs are low and the registers hold these values:
  - control (address 2) reads 0x0009: no-reboot set, halt set.
  - timeout (address 1) reads TMO_RST.
  - count (address 0) reads TMO_RST.
  - both status registers read 0.
- R2: While halt (control bit 3) is 0, the count decrements by one every PRESCALE clocks. While halt is 1, the count holds.
- R3: A write to address 0 with byte enable 0 set loads the count from the timeout register, whatever the data. A write to the timeout register alone leaves the count unchanged.
- R4: A timeout write merges the enabled bytes and masks the result to TMO_W bits (8 or 16). A resulting value below 2 is stored as 2.
- R5: A tick at count 0 with the timeout flag (address 3 bit 3) clear sets that flag and reloads the count. If interrupt enable (control bit 1) is set, smi_o pulses high for exactly one cycle.
- R6: A tick at count 0 with the timeout flag already set has three effects:
  - it sets the second-timeout flag (address 4 bit 1);
  - it sets the boot flag (address 4 bit 2);
  - it pulses rst_req_o for one cycle, unless no-reboot is in effect.
- R7: Status flags are write-one-to-clear. Writing 0 to a flag leaves it unchanged.
- R8: One write to address 4 carrying 1 in both bit 1 and bit 2 clears only bit 1. Bit 2 needs its own write.
- R9: Control writes honour the byte enables. A write with only byte enable 0 changes bits 7:0 and leaves bit 9 unchanged.
- R10: The second-timeout and boot flags survive rst_ni. Only por_ni clears them.
- R11: While lock_i is high, no-reboot reads back as 1 and no reset request is issued, even if software has written no-reboot to 0.
- R12: With interrupt enable 0, a first expiry sets the timeout flag without any pulse on smi_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; leaves the second-timeout and boot flags untouched |
| por_ni | input | 1 | Active-low asynchronous power-on reset; clears everything |
| lock_i | input | 1 | Forces no-reboot on |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_be_i | input | 2 | Byte enables for the write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| smi_o | output | 1 | One-cycle system-management interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is a second expiry. It needs a full timeout period to run out with the timeout flag deliberately left uncleared. It must then be followed by an ordinary reset, after which the sticky flags are read back. The bench uses a prescaler of 3 and short timeouts. It polls the status registers through the bus until each flag appears, then pulses rst_ni and por_ni separately. The locked case repeats the double expiry with the lock held, and shows that no reset pulse appears even though no-reboot was written to 0.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    A_RELOAD = 3'd0,
    A_TMO    = 3'd1,
    A_CTRL   = 3'd2,
    A_STS1   = 3'd3,
    A_STS2   = 3'd4
  } wdt_addr_e;

  localparam int B_NR    = 0;
  localparam int B_SMIEN = 1;
  localparam int B_HALT  = 3;
  localparam int B_SPARE = 9;
  localparam int B_TO    = 3;
  localparam int B_SEC   = 1;
  localparam int B_BOOT  = 2;
  localparam int MIN_TMO = 2;

  function automatic logic [15:0] be_merge(logic [15:0] old_v, logic [15:0] new_v,
                                           logic [1:0] be);
    logic [15:0] r;
    r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
    r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
    return r;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESCALE = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  if (PRESCALE <= 1) begin : g_bypass
    assign tick_o = 1'b1;
  end else begin : g_div
    logic [PW-1:0] pre_q;
    assign tick_o = (pre_q == PW'(PRESCALE - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pre_q <= '0;
      else if (tick_o) pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TMO_W   = 8,
  parameter int TMO_RST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic [TMO_W-1:0] cnt_o,
  output logic             expire_o
);
  logic run;
  assign run      = tick_i & ~halt_i;
  // reload request wins over an expiry in the same cycle
  assign expire_o = run & (cnt_o == '0) & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= TMO_W'(TMO_RST);
    else if (reload_i) cnt_o <= tmo_i;
    else if (run)      cnt_o <= (cnt_o == '0) ? tmo_i : cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        expire_i,
  input  logic        smi_en_i,
  input  logic        no_reboot_i,
  input  logic        wr_sts1_i,
  input  logic        wr_sts2_i,
  input  logic [15:0] wdata_i,
  output logic        to_sts_o,
  output logic        sec_sts_o,
  output logic        boot_sts_o,
  output logic        smi_o,
  output logic        rst_req_o
);
  import wdt_pkg::*;

  logic first_exp, second_exp;
  assign first_exp  = expire_i & ~to_sts_o;
  assign second_exp = expire_i & to_sts_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_sts_o  <= 1'b0;
      smi_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      smi_o     <= first_exp & smi_en_i;
      rst_req_o <= second_exp & ~no_reboot_i;
      if (first_exp)                      to_sts_o <= 1'b1;
      else if (wr_sts1_i && wdata_i[B_TO]) to_sts_o <= 1'b0;
    end
  end

  // sticky flags, power-on reset only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      sec_sts_o  <= 1'b0;
      boot_sts_o <= 1'b0;
    end else if (second_exp) begin
      sec_sts_o  <= 1'b1;
      boot_sts_o <= 1'b1;
    end else if (wr_sts2_i) begin
      if (wdata_i[B_SEC])       sec_sts_o  <= 1'b0;
      else if (wdata_i[B_BOOT]) boot_sts_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int PRESCALE = 1024,
  parameter int TMO_W    = 8,
  parameter int TMO_RST  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        lock_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [1:0]  reg_be_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        smi_o,
  output logic        rst_req_o
);
  logic             rst_n;
  logic             tick;
  logic [TMO_W-1:0] tmo_q, cnt_q, tmo_masked, tmo_new;
  logic [15:0]      tmo_merged;
  logic             nr_q, smien_q, halt_q, spare_q, nr_eff;
  logic             wr_tmo, wr_ctrl, wr_sts1, wr_sts2, reload_wr, expire;
  logic             to_sts, sec_sts, boot_sts, clr_sec;

  assign rst_n     = rst_ni & por_ni;
  assign nr_eff    = nr_q | lock_i;
  assign reload_wr = reg_we_i && (reg_addr_i == A_RELOAD) && reg_be_i[0];
  assign wr_tmo    = reg_we_i && (reg_addr_i == A_TMO) && (|reg_be_i);
  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_sts1   = reg_we_i && (reg_addr_i == A_STS1) && reg_be_i[0];
  assign wr_sts2   = reg_we_i && (reg_addr_i == A_STS2) && reg_be_i[0];
  assign clr_sec   = wr_sts2 & reg_wdata_i[B_SEC];

  assign tmo_merged = be_merge(16'(tmo_q), reg_wdata_i, reg_be_i);
  assign tmo_masked = tmo_merged[TMO_W-1:0];
  assign tmo_new    = (tmo_masked < TMO_W'(MIN_TMO)) ? TMO_W'(MIN_TMO) : tmo_masked;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= TMO_W'(TMO_RST);
      nr_q    <= 1'b1;
      smien_q <= 1'b0;
      halt_q  <= 1'b1;
      spare_q <= 1'b0;
    end else begin
      if (wr_tmo) tmo_q <= tmo_new;
      if (wr_ctrl && reg_be_i[0]) begin
        nr_q    <= reg_wdata_i[B_NR];
        smien_q <= reg_wdata_i[B_SMIEN];
        halt_q  <= reg_wdata_i[B_HALT];
      end
      if (wr_ctrl && reg_be_i[1]) spare_q <= reg_wdata_i[B_SPARE];
    end
  end

  wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .tick_o(tick)
  );

  wdt_counter #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .halt_i  (halt_q),
    .reload_i(reload_wr),
    .tmo_i   (tmo_q),
    .cnt_o   (cnt_q),
    .expire_o(expire)
  );

  wdt_status u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .por_ni     (por_ni),
    .expire_i   (expire),
    .smi_en_i   (smien_q),
    .no_reboot_i(nr_eff),
    .wr_sts1_i  (wr_sts1),
    .wr_sts2_i  (wr_sts2),
    .wdata_i    (reg_wdata_i),
    .to_sts_o   (to_sts),
    .sec_sts_o  (sec_sts),
    .boot_sts_o (boot_sts),
    .smi_o      (smi_o),
    .rst_req_o  (rst_req_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_RELOAD: reg_rdata_o = 16'(cnt_q);
      A_TMO:    reg_rdata_o = 16'(tmo_q);
      A_CTRL: begin
        reg_rdata_o[B_NR]    = nr_eff;
        reg_rdata_o[B_SMIEN] = smien_q;
        reg_rdata_o[B_HALT]  = halt_q;
        reg_rdata_o[B_SPARE] = spare_q;
      end
      A_STS1: reg_rdata_o[B_TO] = to_sts;
      A_STS2: begin
        reg_rdata_o[B_SEC]  = sec_sts;
        reg_rdata_o[B_BOOT] = boot_sts;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int TMO_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             lock_i,
  input logic             halt_q,
  input logic             reload_wr,
  input logic [TMO_W-1:0] cnt_q,
  input logic             sec_sts,
  input logic             clr_sec,
  input logic             smi_o,
  input logic             rst_req_o
);
  AST_SMI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    smi_o |=> !smi_o); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rst_req_o |=> !rst_req_o); // R6
  AST_RST_WITH_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rst_req_o |-> sec_sts); // R6
  AST_LOCK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $past(lock_i) |-> !rst_req_o); // R11
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    ($past(halt_q) && !$past(reload_wr)) |-> (cnt_q == $past(cnt_q))); // R2
  AST_SEC_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    ($past(sec_sts) && !$past(clr_sec)) |-> sec_sts); // R10
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.TMO_W(TMO_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .por_ni   (por_ni),
  .lock_i   (lock_i),
  .halt_q   (halt_q),
  .reload_wr(reload_wr),
  .cnt_q    (cnt_q),
  .sec_sts  (sec_sts),
  .clr_sec  (clr_sec),
  .smi_o    (smi_o),
  .rst_req_o(rst_req_o)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  localparam int PRE  = 3;
  localparam int TW   = 8;
  localparam int TRST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0, lock = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [1:0] be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic smi, rreq;

  int n_chk = 0, n_fail = 0, cyc = 0, smi_cnt = 0, rst_cnt = 0;

  always #2 clk = ~clk;

  wdt_two_stage #(.PRESCALE(PRE), .TMO_W(TW), .TMO_RST(TRST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .lock_i(lock),
    .reg_we_i(we), .reg_addr_i(addr), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .smi_o(smi), .rst_req_o(rreq)
  );

  // behavioural reference model
  int m_pre, m_cnt, m_tmo, v;
  bit m_nr, m_smien, m_halt, m_spare, m_to, m_sec, m_boot, m_smi, m_rst;
  bit t_tick, t_rl, t_run, t_ex;
  int old_tmo;
  logic [15:0] merged;

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n || !rst_n) begin
      m_pre = 0; m_cnt = TRST; m_tmo = TRST;
      m_nr = 1; m_smien = 0; m_halt = 1; m_spare = 0;
      m_to = 0; m_smi = 0; m_rst = 0;
      if (!por_n) begin m_sec = 0; m_boot = 0; end
    end else begin
      t_tick  = (m_pre == PRE - 1);
      t_rl    = we && addr == 3'd0 && be[0];
      t_run   = t_tick && !m_halt;
      t_ex    = t_run && m_cnt == 0 && !t_rl;
      old_tmo = m_tmo;
      m_pre   = t_tick ? 0 : m_pre + 1;
      m_smi   = t_ex && !m_to && m_smien;
      m_rst   = t_ex && m_to && !(m_nr || lock);
      if (t_rl) m_cnt = old_tmo;
      else if (t_run) m_cnt = (m_cnt == 0) ? old_tmo : m_cnt - 1;
      if (t_ex && m_to) begin m_sec = 1; m_boot = 1; end
      else if (we && addr == 3'd4 && be[0]) begin
        if (wdata[1]) m_sec = 0;
        else if (wdata[2]) m_boot = 0;
      end
      if (t_ex && !m_to) m_to = 1;
      else if (we && addr == 3'd3 && be[0] && wdata[3]) m_to = 0;
      if (we && addr == 3'd1 && be != 2'b00) begin
        merged[7:0]  = be[0] ? wdata[7:0] : 8'(m_tmo);
        merged[15:8] = be[1] ? wdata[15:8] : 8'h00;
        v = int'(merged[7:0]);
        m_tmo = (v < 2) ? 2 : v;
      end
      if (we && addr == 3'd2 && be[0]) begin
        m_nr = wdata[0]; m_smien = wdata[1]; m_halt = wdata[3];
      end
      if (we && addr == 3'd2 && be[1]) m_spare = wdata[9];
    end
  end

  function automatic logic [15:0] model_rd(logic [2:0] a);
    logic [15:0] r = '0;
    case (a)
      3'd0: r = 16'(m_cnt);
      3'd1: r = 16'(m_tmo);
      3'd2: begin r[0] = m_nr | lock; r[1] = m_smien; r[3] = m_halt; r[9] = m_spare; end
      3'd3: r[3] = m_to;
      3'd4: begin r[1] = m_sec; r[2] = m_boot; end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && por_n) begin
      check("R3 rdata vs model", rdata, model_rd(addr));
      check("R5 smi_o vs model", 16'(smi), 16'(m_smi));
      check("R6 rst_req_o vs model", 16'(rreq), 16'(m_rst));
    end
  end

  always @(negedge clk) begin
    if (smi) smi_cnt++;
    if (rreq) rst_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk); addr = a; wdata = d; be = b; we = 1'b1;
    @(negedge clk); we = 1'b0; be = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [15:0] exp, string tag);
    logic [15:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic wait_bit(logic [2:0] a, logic [15:0] mask, string tag);
    bit found = 0;
    for (int i = 0; i < 3000 && !found; i++) begin
      @(negedge clk); addr = a; #1;
      if ((rdata & mask) != 0) found = 1;
    end
    check(tag, 16'(found), 16'd1);
  endtask

  task automatic pulse_reset(bit power);
    @(negedge clk);
    if (power) por_n = 1'b0; else rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] c1, c2;
    int s0, r0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    rd_chk(3'd2, 16'h0009, "R1 ctrl default");
    rd_chk(3'd1, 16'(TRST), "R1 timeout default");
    rd_chk(3'd0, 16'(TRST), "R1 count default");
    rd_chk(3'd3, 16'h0000, "R1 sts1 default");
    rd_chk(3'd4, 16'h0000, "R1 sts2 default");
    check("R1 outputs low", {14'd0, smi, rreq}, 16'h0000);

    // R4 clamp and mask
    wr(3'd1, 16'h0001, 2'b11);
    rd_chk(3'd1, 16'h0002, "R4 clamp to 2");
    wr(3'd1, 16'h01FF, 2'b11);
    rd_chk(3'd1, 16'h00FF, "R4 mask to width");
    wr(3'd1, 16'h0006, 2'b01);
    // R3 timeout write leaves count, reload loads it
    rd_chk(3'd0, 16'(TRST), "R3 count unchanged by timeout write");
    wr(3'd0, 16'h0013, 2'b01);
    rd_chk(3'd0, 16'h0006, "R3 reload from timeout");

    // R9 byte enables on control
    wr(3'd2, 16'h0209, 2'b11);
    rd_chk(3'd2, 16'h0209, "R9 spare bit set");
    wr(3'd2, 16'h0000, 2'b01);
    rd_chk(3'd2, 16'h0200, "R9 low-byte write keeps bit 9");

    // R2 running then halted
    rd(3'd0, c1);
    repeat (5) @(negedge clk);
    rd(3'd0, c2);
    check("R2 decrement per prescale", c2, c1 - 16'd2);
    wr(3'd2, 16'h0008, 2'b01);
    rd(3'd0, c1);
    repeat (10) @(negedge clk);
    rd(3'd0, c2);
    check("R2 halted count holds", c2, c1);

    // R12 first expiry without interrupt
    wr(3'd1, 16'd40, 2'b01);
    wr(3'd0, 16'h0000, 2'b01);
    s0 = smi_cnt;
    wr(3'd2, 16'h0000, 2'b01);
    wait_bit(3'd3, 16'h0008, "R5 first expiry sets timeout flag");
    check("R12 no smi pulse when disabled", 16'(smi_cnt - s0), 16'd0);

    // R7 write-one-to-clear
    wr(3'd3, 16'h0000, 2'b01);
    rd_chk(3'd3, 16'h0008, "R7 writing 0 keeps flag");
    wr(3'd3, 16'h0008, 2'b01);
    rd_chk(3'd3, 16'h0000, "R7 writing 1 clears flag");

    // R5 and R6 with interrupt on, reboot allowed
    s0 = smi_cnt; r0 = rst_cnt;
    wr(3'd2, 16'h0002, 2'b01);
    wait_bit(3'd3, 16'h0008, "R5 first expiry again");
    check("R5 one smi pulse", 16'(smi_cnt - s0), 16'd1);
    check("R5 no reset on first expiry", 16'(rst_cnt - r0), 16'd0);
    wait_bit(3'd4, 16'h0006, "R6 second expiry");
    rd_chk(3'd4, 16'h0006, "R6 sec and boot set");
    check("R6 one reset pulse", 16'(rst_cnt - r0), 16'd1);

    // R10 sticky over ordinary reset
    pulse_reset(1'b0);
    rd_chk(3'd4, 16'h0006, "R10 flags survive rst_ni");
    rd_chk(3'd2, 16'h0009, "R1 ctrl default after rst_ni");
    // R8 both ones clears only bit 1
    wr(3'd4, 16'h0006, 2'b01);
    rd_chk(3'd4, 16'h0004, "R8 only second-timeout cleared");
    pulse_reset(1'b1);
    rd_chk(3'd4, 16'h0000, "R10 por clears boot flag");

    // R11 lock forces no-reboot
    lock = 1'b1;
    r0 = rst_cnt;
    wr(3'd2, 16'h0002, 2'b01);
    rd_chk(3'd2, 16'h0003, "R11 no-reboot reads 1 under lock");
    wait_bit(3'd4, 16'h0002, "R11 second expiry under lock");
    check("R11 reset suppressed", 16'(rst_cnt - r0), 16'd0);
    lock = 1'b0;
    rd_chk(3'd2, 16'h0002, "R11 no-reboot after unlock");
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule